// File: doc/BRIEF.md
# Cache Victim Way Selector with Lockdown

This block picks which way of a set-associative cache receives the next line fill. It runs in one of two policies: a round-robin pointer that steps through the ways in turn, or a pseudo-random choice taken from a linear feedback shift register. The cache presents an allocate strobe whenever it fills a line and reads the victim way number from the block in the same cycle. The selector's internal state then advances on the clock edge that ends that cycle.

A lockdown register shields the low ways of every set from replacement. A way index of N written with the load flag clear sets a lockdown base. Ways 0 to N-1 in every set are then never offered as victims. A write with the load flag set instead puts the block into load mode. In load mode every fill goes to the written way, so software can preload locked content one way at a time. When all ways are locked the block raises a no-victim flag, and the cache treats the access as non-allocating. Invalidation is not handled here: a locked line can still be invalidated by the cache, because lockdown only limits which way the replacement logic chooses.

Top module: `victim_select`

## Requirements
- R1: After reset the lockdown base is 0, load mode is off, the round-robin pointer is 0 and the LFSR holds 16'hACE1. In round-robin mode victimWay is then 0 and noVictim is 0.
- R2: In round-robin mode, outside load mode and with a victim available, victimWay shows the pointer. Each allocate strobe steps the pointer by one, and the new value is visible the cycle after the strobe. From WAYS-1 the pointer wraps to the lockdown base, not to 0.
- R3: In random mode, outside load mode and with base N < WAYS, victimWay = N + (L mod (WAYS-N)), where L is the 16-bit LFSR state. Each allocate strobe in random mode updates L to {L[14:0], L[15]^L[13]^L[12]^L[10]}.
- R4: A lockdown write with lockLoad=0 sets the base to N = min(lockIdx, WAYS). From the next cycle on, every victim outside load mode lies in [N, WAYS-1].
- R5: When a base write leaves the pointer below a new base N < WAYS, the pointer is raised to N. If the pointer is already at or above N, or if N = WAYS, the pointer is left unchanged. An allocation in the same cycle as the base write steps the pointer first, using the old base.
- R6: A lockdown write with lockLoad=1 enters load mode. From the next cycle on, victimWay is min(lockIdx, WAYS-1) in either policy, and noVictim is 0. Allocations in load mode advance neither the pointer nor the LFSR, and they leave the base unchanged.
- R7: With base N = WAYS and load mode off, noVictim is 1 and victimWay is 0. Allocate strobes then advance neither the pointer nor the LFSR.
- R8: A lockdown write of index 0 with lockLoad=0 ends load mode and clears the base to 0, so all ways become eligible again. The pointer is left unchanged.
- R9: Without an allocate strobe, the pointer and the LFSR hold their values. An allocation in random mode leaves the pointer unchanged, and an allocation in round-robin mode leaves the LFSR unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| allocStb | input | 1 | A line fill uses victimWay in this cycle |
| modeRand | input | 1 | Policy select: 0 round-robin, 1 pseudo-random |
| lockWr | input | 1 | Write to the lockdown register |
| lockIdx | input | $clog2(WAYS+1) | Way index carried by the lockdown write |
| lockLoad | input | 1 | Load flag carried by the lockdown write |
| victimWay | output | $clog2(WAYS) | Way chosen for the current fill |
| noVictim | output | 1 | No way is eligible; the access must not allocate |

## Verification
The assertions assume that modeRand changes only between cycles. They also assume that a round-robin step is judged only when the policy is held across the step and no lockdown write occurs in the same cycle, so the check of the next victim excludes cycles with a policy change or a write. The inputs may carry out-of-range index values, and the clamping rules are what keep the range assertions valid. The stimulus holds each policy for bursts of fifty cycles. It writes lockIdx values up to WAYS+1, mixes load-mode writes with base writes, and lets writes coincide with allocations so that the ordering in R5 is exercised.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef struct packed {
    logic advPtr;
    logic advLfsr;
    logic setBase;
  } strobe_t;
endpackage

// File: rtl/vs_lfsr.sv
module vs_lfsr #(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  logic feedback;
  assign feedback = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else if (adv) state <= {state[LFSR_W-2:0], feedback};
  end
endmodule

// File: rtl/vs_ctrl.sv
module vs_ctrl
  import vs_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int BASE_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocStb,
  input  logic              modeRand,
  input  logic              lockWr,
  input  logic [BASE_W-1:0] lockIdx,
  input  logic              lockLoad,
  input  logic              baseFull,
  output strobe_t           strb,
  output logic              inLoad,
  output logic [WAY_W-1:0]  loadWay
);
  localparam logic [BASE_W-1:0] WAYS_B = BASE_W'(WAYS);
  localparam logic [WAY_W-1:0]  LAST_WAY = WAY_W'(WAYS - 1);

  logic normalAlloc;
  logic [WAY_W-1:0] loadWayNext;

  assign normalAlloc = allocStb && !inLoad && !baseFull;

  always_comb begin
    strb.advPtr  = normalAlloc && !modeRand;
    strb.advLfsr = normalAlloc && modeRand;
    strb.setBase = lockWr && !lockLoad;
  end

  assign loadWayNext = (lockIdx >= WAYS_B) ? LAST_WAY : lockIdx[WAY_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inLoad  <= 1'b0;
      loadWay <= '0;
    end else if (lockWr) begin
      inLoad <= lockLoad;
      if (lockLoad) loadWay <= loadWayNext;
    end
  end
endmodule

// File: rtl/vs_datapath.sv
module vs_datapath
  import vs_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int WAY_W = $clog2(WAYS),
  localparam int BASE_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [BASE_W-1:0] lockIdx,
  input  logic              modeRand,
  input  logic              inLoad,
  input  logic [WAY_W-1:0]  loadWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic              noVictim,
  output logic [BASE_W-1:0] curBase,
  output logic              baseFull
);
  localparam logic [BASE_W-1:0] WAYS_B = BASE_W'(WAYS);
  localparam logic [WAY_W-1:0]  LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0]  rrPtr, ptrStep, ptrNext;
  logic [BASE_W-1:0] baseNext, eligible;
  logic [LFSR_W-1:0] lfsrState, randOff;
  logic [WAY_W-1:0]  randWay;

  vs_lfsr #(.LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(strb.advLfsr), .state(lfsrState)
  );

  assign baseFull = (curBase == WAYS_B);
  assign baseNext = (lockIdx > WAYS_B) ? WAYS_B : lockIdx;

  always_comb begin
    if (rrPtr == LAST_WAY) ptrStep = curBase[WAY_W-1:0];
    else ptrStep = rrPtr + WAY_W'(1);
    ptrNext = strb.advPtr ? ptrStep : rrPtr;
    if (strb.setBase && (baseNext < WAYS_B) && ({1'b0, ptrNext} < baseNext))
      ptrNext = baseNext[WAY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrPtr   <= '0;
      curBase <= '0;
    end else begin
      rrPtr <= ptrNext;
      if (strb.setBase) curBase <= baseNext;
    end
  end

  assign eligible = WAYS_B - curBase;

  always_comb begin
    if (eligible == '0) randOff = '0;
    else randOff = lfsrState % LFSR_W'(eligible);
    randWay = curBase[WAY_W-1:0] + randOff[WAY_W-1:0];
  end

  always_comb begin
    noVictim = baseFull && !inLoad;
    if (inLoad) victimWay = loadWay;
    else if (baseFull) victimWay = '0;
    else if (modeRand) victimWay = randWay;
    else victimWay = rrPtr;
  end
endmodule

// File: rtl/victim_select.sv
module victim_select
  import vs_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int WAY_W = $clog2(WAYS),
  localparam int BASE_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocStb,
  input  logic              modeRand,
  input  logic              lockWr,
  input  logic [BASE_W-1:0] lockIdx,
  input  logic              lockLoad,
  output logic [WAY_W-1:0]  victimWay,
  output logic              noVictim
);
  strobe_t strb;
  logic inLoad, baseFull;
  logic [WAY_W-1:0] loadWay;
  logic [BASE_W-1:0] curBase;

  vs_ctrl #(.WAYS(WAYS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .allocStb(allocStb), .modeRand(modeRand),
    .lockWr(lockWr), .lockIdx(lockIdx), .lockLoad(lockLoad),
    .baseFull(baseFull), .strb(strb), .inLoad(inLoad), .loadWay(loadWay)
  );

  vs_datapath #(.WAYS(WAYS), .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .lockIdx(lockIdx),
    .modeRand(modeRand), .inLoad(inLoad), .loadWay(loadWay),
    .victimWay(victimWay), .noVictim(noVictim), .curBase(curBase),
    .baseFull(baseFull)
  );
endmodule

// File: rtl/vs_checker.sv
module vs_checker #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int BASE_W = $clog2(WAYS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              allocStb,
  input logic              modeRand,
  input logic              lockWr,
  input logic [BASE_W-1:0] lockIdx,
  input logic              lockLoad,
  input logic [WAY_W-1:0]  victimWay,
  input logic              noVictim,
  input logic [BASE_W-1:0] curBase,
  input logic              inLoad
);
  localparam logic [BASE_W-1:0] WAYS_B = BASE_W'(WAYS);
  localparam logic [WAY_W-1:0]  LAST_WAY = WAY_W'(WAYS - 1);

  // R4
  victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!noVictim && !inLoad) |-> ({1'b0, victimWay} >= curBase));

  // R2
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allocStb && !modeRand && !inLoad && !noVictim && !lockWr) |=>
      (modeRand || (victimWay == (($past(victimWay) == LAST_WAY) ?
        $past(curBase[WAY_W-1:0]) : $past(victimWay) + WAY_W'(1)))));

  // R6
  load_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockWr && lockLoad) |=> (!noVictim && (victimWay ==
      (($past(lockIdx) >= WAYS_B) ? LAST_WAY : $past(lockIdx[WAY_W-1:0])))));

  // R7
  no_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockWr && !lockLoad && (lockIdx >= WAYS_B)) |=> (noVictim && victimWay == '0));

  // R8
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockWr && !lockLoad && lockIdx == '0) |=> (!noVictim && !inLoad && curBase == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!allocStb && !lockWr) |=> ((modeRand != $past(modeRand)) || $stable(victimWay)));
endmodule

bind victim_select vs_checker #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .allocStb(allocStb), .modeRand(modeRand),
  .lockWr(lockWr), .lockIdx(lockIdx), .lockLoad(lockLoad),
  .victimWay(victimWay), .noVictim(noVictim), .curBase(curBase),
  .inLoad(inLoad)
);

// File: tb/sim_victim_select.sv
`timescale 1ns/1ps
module sim_victim_select;
  localparam int WAYS = 8;
  localparam int WAY_W = $clog2(WAYS);
  localparam int BASE_W = $clog2(WAYS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic allocStb = 0, modeRand = 0, lockWr = 0, lockLoad = 0;
  logic [BASE_W-1:0] lockIdx = '0;
  logic [WAY_W-1:0] victimWay;
  logic noVictim;

  int checks = 0, errors = 0;
  bit done = 0;

  int mBase, mPtr, mLoadWay;
  bit mLoad;
  logic [15:0] mLfsr;

  always #2.5 clk = ~clk;

  victim_select #(.WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .allocStb(allocStb), .modeRand(modeRand),
    .lockWr(lockWr), .lockIdx(lockIdx), .lockLoad(lockLoad),
    .victimWay(victimWay), .noVictim(noVictim)
  );

  function automatic logic [15:0] lfsrStep(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic int expWay(bit rnd);
    if (mLoad) return mLoadWay;
    if (mBase == WAYS) return 0;
    if (rnd) return mBase + int'(mLfsr % 16'(WAYS - mBase));
    return mPtr;
  endfunction

  function automatic string autoTag(bit rnd);
    if (mLoad) return "R6";
    if (mBase == WAYS) return "R7";
    return rnd ? "R3" : "R2";
  endfunction

  task automatic check(string tag);
    int ew;
    bit en;
    ew = expWay(modeRand);
    en = !mLoad && (mBase == WAYS);
    if (tag == "") tag = autoTag(modeRand);
    checks++;
    if (int'(victimWay) != ew || noVictim != en) begin
      errors++;
      $display("FAIL %s: victimWay=%0d noVictim=%0d expected %0d/%0d",
               tag, victimWay, noVictim, ew, en);
    end
  endtask

  task automatic step(bit a, bit rnd, bit w, int idx, bit ld, string tag);
    int np;
    logic [15:0] nl;
    allocStb = a; modeRand = rnd; lockWr = w;
    lockIdx = BASE_W'(idx); lockLoad = ld;
    @(posedge clk);
    np = mPtr; nl = mLfsr;
    if (a && !mLoad && mBase != WAYS) begin
      if (rnd) nl = lfsrStep(mLfsr);
      else np = (mPtr == WAYS - 1) ? mBase : mPtr + 1;
    end
    if (w) begin
      if (ld) begin
        mLoad = 1; mLoadWay = (idx >= WAYS) ? WAYS - 1 : idx;
      end else begin
        mLoad = 0;
        mBase = (idx > WAYS) ? WAYS : idx;
        if (mBase < WAYS && np < mBase) np = mBase;
      end
    end
    mPtr = np; mLfsr = nl;
    @(negedge clk);
    allocStb = 0; lockWr = 0;
    check(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int burstRnd;
    mBase = 0; mPtr = 0; mLoad = 0; mLoadWay = 0; mLfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");
    // R2 wrap with base 0
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, "R2");
    // R5 floor: pointer 2 raised to base 5
    step(0, 0, 1, 5, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R4");
    // R5 pointer above new base stays
    step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 2, 0, "R5");
    // R3 random with base 2
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, "R3");
    // R9 hold and mode separation
    step(0, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, "R9");
    step(0, 1, 0, 0, 0, "R9");
    // R6 load mode, out-of-range index clamps
    step(0, 1, 1, 1, 1, "R6");
    step(1, 1, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 9, 1, "R6");
    step(0, 1, 1, 2, 0, "R6");
    // R7 all locked, clamped index
    step(0, 0, 1, 9, 0, "R7");
    step(1, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, "R7");
    // R8 unlock
    step(0, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    // constrained random
    void'($urandom(32'd17));
    burstRnd = 0;
    for (int i = 0; i < 3000; i++) begin
      bit a, w, ld;
      int idx;
      if (i % 50 == 0) burstRnd = int'($urandom_range(0, 1));
      a = ($urandom_range(0, 9) < 6);
      w = ($urandom_range(0, 99) < 8);
      ld = ($urandom_range(0, 9) < 3);
      idx = int'($urandom_range(0, WAYS + 1));
      step(a, burstRnd[0], w, idx, ld, "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule